// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns a single externally supplied start address into the sequence of addresses a short memory burst visits. A load command stores the whole address. Each advance command then moves to the next beat by stepping only the low offset bits. The upper bits stay fixed for the whole burst. Two stepping orders exist. Linear order counts up modulo the burst length from the starting offset. Interleaved order XORs the beat number into the starting offset. After the last beat the sequence returns to the start.

The order is chosen by a static strap input that is never clocked. An active-low clock enable freezes all state, so the sequencer stalls in step with the memory pipeline around it. The output address is a registered base combined with the beat count, so it is valid in the cycle after the command that produced it.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, the registered state clears, so that one clock edge later `addrOut` is all zeros.
- R2: At an edge where `clkEnN` is 0 and `load` is 1, the full `startAddr` is stored, and `addrOut` equals it after that edge.
- R3: With `interleave` = 0 (linear order), each enabled advance raises the low `OFS_W` bits of `addrOut` by 1 modulo 2^OFS_W. From a start offset of 1 the sequence is 1, 2, 3, 0.
- R4: With `interleave` = 1 (interleaved order), the low bits after k advances equal the start offset XOR k. From a start offset of 1 the sequence is 1, 0, 3, 2.
- R5: After 2^OFS_W advances, `addrOut` is back at the loaded start address, in either order.
- R6: An advance never changes `addrOut` bits above the low `OFS_W` bits. A linear step from offset 3 to 0 does not carry into the upper bits.
- R7: At an edge where `clkEnN` is 1, `load` and `advance` are ignored, and `addrOut` keeps its value.
- R8: When `load` and `advance` are both 1 at an enabled edge, the load wins, and `addrOut` becomes `startAddr` at beat 0.
- R9: `interleave` is not clocked. Changing it alters `addrOut` at once, from the stored start offset and beat count, without changing the beat count.
- R10: An enabled edge that has neither `load` nor `advance` leaves `addrOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clkEnN | input | 1 | Clock enable, active low; 1 freezes all state |
| load | input | 1 | Store `startAddr` and restart at beat 0 |
| advance | input | 1 | Step to the next beat |
| interleave | input | 1 | Static order strap: 0 linear, 1 interleaved |
| startAddr | input | ADDR_W | Full starting address of the burst |
| addrOut | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with `ADDR_W` = 12 and keeps the default `OFS_W` = 2, so every address is three readable hex digits and a burst is four beats. Start addresses with all upper bits set (0xFFE) and with offset 3 bring within reach any carry that leaks from the offset into the upper bits. The short burst lets the bench watch a full wrap in each order. It also switches the strap in the middle of a burst, which shows the order is combinational while the beat count is kept.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Per-edge commands from control to datapath
  typedef struct packed {
    logic loadStb;  // capture start address, clear beat count
    logic stepStb;  // increment beat count
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic          clkEnN,
  input  logic          load,
  input  logic          advance,
  output burstStrobes_t strb
);
  logic enabled;

  assign enabled = !clkEnN;

  always_comb begin
    strb         = '0;
    // load takes priority over advance; a high enable freezes everything
    strb.loadStb = enabled && load;
    strb.stepStb = enabled && !load && advance;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  burstStrobes_t     strb,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [OFS_W-1:0]  beatCnt;
  logic [OFS_W-1:0]  baseOfs;
  logic [OFS_W-1:0]  linearOfs;
  logic [OFS_W-1:0]  xorOfs;
  logic [OFS_W-1:0]  curOfs;
  logic [UPPER_W-1:0] upperBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strb.loadStb) begin
      baseAddr <= startAddr;
      beatCnt  <= '0;
    end else if (strb.stepStb) begin
      beatCnt  <= beatCnt + 1'b1;  // natural wrap at 2**OFS_W
    end
  end

  assign baseOfs   = baseAddr[OFS_W-1:0];
  assign upperBits = baseAddr[ADDR_W-1:OFS_W];
  assign linearOfs = baseOfs + beatCnt;
  assign xorOfs    = baseOfs ^ beatCnt;
  // strap is unclocked: the order mux sits after the registers
  assign curOfs    = interleave ? xorOfs : linearOfs;
  assign addrOut   = {upperBits, curOfs};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              load,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] addrOut
);
  burstStrobes_t strb;

  burst_ctrl u_ctrl (
    .clkEnN  (clkEnN),
    .load    (load),
    .advance (advance),
    .strb    (strb)
  );

  burst_datapath #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .interleave (interleave),
    .startAddr  (startAddr),
    .addrOut    (addrOut)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEnN,
  input logic              load,
  input logic              advance,
  input logic              interleave,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] addrOut
);
  logic [OFS_W-1:0]        lowBits;
  logic [ADDR_W-OFS_W-1:0] highBits;

  assign lowBits  = addrOut[OFS_W-1:0];
  assign highBits = addrOut[ADDR_W-1:OFS_W];

  // R1: reset forces a zero address
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (addrOut == '0));

  // R2 / R8: enabled load captures the full address
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && load) |=> (addrOut == $past(startAddr)));

  // R3: linear step adds one to the offset
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !load && advance && !interleave) |=>
      (interleave || lowBits == OFS_W'($past(lowBits) + 1'b1)));

  // R6: advance never touches the upper bits
  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !load && advance) |=> (highBits == $past(highBits)));

  // R7: disabled edge keeps the address (unless the unclocked strap moved)
  assert_hold_when_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> ($stable(addrOut) || !$stable(interleave)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clkEnN     (clkEnN),
  .load       (load),
  .advance    (advance),
  .interleave (interleave),
  .startAddr  (startAddr),
  .addrOut    (addrOut)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 12;
  localparam int NV = 16;

  typedef struct packed {
    logic          enN;
    logic          ld;
    logic          adv;
    logic          il;
    logic [AW-1:0] start;
    logic [AW-1:0] expAddr;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 12'h5A1, 12'h5A1, 4'd2},  // R2 load, linear
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h5A2, 4'd3},  // R3
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h5A3, 4'd3},
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h5A0, 4'd6},  // R6 no carry
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h5A1, 4'd5},  // R5 wrap
    '{1'b0, 1'b1, 1'b0, 1'b1, 12'hFFE, 12'hFFE, 4'd2},  // R2 interleaved load
    '{1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 12'hFFF, 4'd4},  // R4 2^1
    '{1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 12'hFFC, 4'd4},  // R4 2^2
    '{1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 12'hFFD, 4'd4},  // R4 2^3
    '{1'b0, 1'b0, 1'b1, 1'b1, 12'h000, 12'hFFE, 4'd5},  // R5 wrap
    '{1'b1, 1'b1, 1'b1, 1'b1, 12'h123, 12'hFFE, 4'd7},  // R7 frozen
    '{1'b0, 1'b0, 1'b0, 1'b1, 12'h456, 12'hFFE, 4'd10}, // R10 idle
    '{1'b0, 1'b1, 1'b1, 1'b0, 12'h3C7, 12'h3C7, 4'd8},  // R8 load wins
    '{1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h3C4, 4'd6},  // R6 3->0 no carry
    '{1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 12'h3C6, 4'd9},  // R9 3^1
    '{1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h3C4, 4'd9}   // R9 back to linear
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clkEnN = 1'b0;
  logic          load = 1'b0;
  logic          advance = 1'b0;
  logic          interleave = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] addrOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  burst_addr_gen #(.ADDR_W(AW), .OFS_W(2)) u_burst_addr_gen (
    .clk        (clk),
    .rst        (rst),
    .clkEnN     (clkEnN),
    .load       (load),
    .advance    (advance),
    .interleave (interleave),
    .startAddr  (startAddr),
    .addrOut    (addrOut)
  );

  task automatic check(input string tag, input logic [AW-1:0] exp);
    chkCnt++;
    if (addrOut !== exp) begin
      errCnt++;
      $display("FAIL %s: addrOut=%h expected=%h", tag, addrOut, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #400000;
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    step();
    check("R1 reset", '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clkEnN     = VECS[i].enN;
      load       = VECS[i].ld;
      advance    = VECS[i].adv;
      interleave = VECS[i].il;
      startAddr  = VECS[i].start;
      step();
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].expAddr);
    end

    // R7: freeze mid burst, then resume the linear sequence
    @(negedge clk);
    clkEnN = 1'b0; load = 1'b1; advance = 1'b0; interleave = 1'b0; startAddr = 12'hABD;
    step();
    check("R2 load 0xABD", 12'hABD);
    @(negedge clk);
    load = 1'b0; advance = 1'b1; clkEnN = 1'b1;
    step();
    step();
    check("R7 frozen advance", 12'hABD);
    @(negedge clk);
    clkEnN = 1'b0;
    step();
    check("R3 resume step", 12'hABE);

    // R1: reset in the middle of a burst
    @(negedge clk);
    rst = 1'b1; advance = 1'b0;
    step();
    check("R1 mid-burst reset", '0);
    @(negedge clk);
    rst = 1'b0;
    step();
    check("R10 idle after reset", '0);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule